// File: doc/BRIEF.md
# Trigger-Configurable 32-Line Interrupt Controller

This block gathers up to 32 asynchronous interrupt request lines into one combined interrupt output. Software picks a trigger type for each line from two configuration bits: one selects edge or level, the other selects the active sense. Every line passes through a two-flop synchroniser before any trigger logic sees it. Edge events are latched in a status register until software clears them by writing ones. Level lines show their qualified level in the same status register. A force register lets software inject an interrupt on any line without the input changing.

An enable mask gates the status bits, and the gated bits are ORed into one pending signal. The combined output can present that signal as a level of either sense, or as a single-cycle pulse each time the pending signal rises. All control is through a simple 32-bit register port with a combinational read path. When software changes the trigger type of a line, the status bit of that line is dropped, so that an event caught under the old type cannot survive the change.

Top module: `irq_trigger_ctrl`

## Requirements
- R1: While reset is held, and at its release, every register reads zero (enable, status, source mode, source polarity, output mode, output polarity, force) and `irq_out` is 1 (active-low level output with nothing pending).
- R2: Register offsets on `reg_addr`: 0x00 enable, 0x04 status, 0x08 source mode, 0x0C source polarity, 0x10 output mode (bit 0), 0x14 output polarity (bit 0), 0x18 force. Written values read back the cycle after the write. Any other offset reads zero.
- R3: A line with mode bit 1 is edge triggered: polarity 1 means rising, polarity 0 means falling. Its status bit is set on the third rising clock edge after the input changes (two synchroniser stages, then the status register).
- R4: Writing 1 to a status bit of an edge line clears it, and writing 0 leaves it unchanged. An edge detected in the same cycle as the clearing write stays latched.
- R5: A line with mode bit 0 is level triggered: polarity 1 means active high, polarity 0 means active low. Its status bit follows the qualified level with the same three-edge latency as R3, and writes to its status bit have no effect.
- R6: A write that changes a line's mode or polarity bit clears that line's status bit on the same clock edge, unless its force bit is set.
- R7: While a force bit is 1, the matching status bit is set on every clock edge. An edge line stays latched after the force bit returns to 0, until it is cleared by a write.
- R8: The pending signal is the OR over all lines of status AND enable. With output mode 0, `irq_out` equals pending when output polarity is 1 and its inverse when output polarity is 0. It follows status and enable with no added cycle.
- R9: With output mode 1, `irq_out` shows a pulse one clock long, one edge after pending rises: it goes high for that clock when output polarity is 1, and low for that clock when output polarity is 0.

Top module port order below is the declaration order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | NSRC (32) | Asynchronous interrupt request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq_out | output | 1 | Combined interrupt output |

## Verification
The bench aims at the cycle where an edge arrives at the same moment as a write-one clear. A design that lets the clear win would lose that interrupt. It rewrites the trigger type of a line whose edge is still latched. A design that skipped the clear would report a stale event under the new type. It writes ones to the status bits of level lines, which a design that lets the write through would show as a brief drop in the level. It also checks the pulse output: a design that held the pulse, or fired it again while pending stayed high, would give a pulse longer than one clock. Random line activity and random register writes are then compared cycle by cycle against a bench model, which catches latency errors in the synchroniser or the status stage.

// File: rtl/irqc_pkg.sv
// Package: register offsets and the read/write port widths shared by the
// trigger-configurable interrupt controller. Assumes byte offsets in 5 bits.
package irqc_pkg;
    localparam int unsigned ADDR_W = 5;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFS_ENABLE  = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_STATUS  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_SMODE   = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_SPOL    = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_OMODE   = 5'h10;
    localparam logic [ADDR_W-1:0] OFS_OPOL    = 5'h14;
    localparam logic [ADDR_W-1:0] OFS_FORCE   = 5'h18;
endpackage

// File: rtl/irqc_sync.sv
// Module: two-flop synchroniser per line, plus one more stage that holds the
// previous synchronised value for edge detection.
// Assumes: inputs are asynchronous; the reset value of every stage is 0.
module irqc_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;
    logic [W-1:0] hist_q;

    // Purpose: shift the raw lines through the meta, stable and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
            hist_q <= '0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
            hist_q <= stab_q;
        end
    end

    assign sync_o = stab_q;
    assign prev_o = hist_q;
endmodule

// File: rtl/irqc_cfg_regs.sv
// Module: configuration registers, write decode and read multiplexer.
// Produces the write-one-clear mask for status and the per-line mask of
// trigger-type changes. Assumes N <= DATA_W; a read has no side effect.
module irqc_cfg_regs
    import irqc_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [N-1:0]      status_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic [N-1:0]      enable_o,
    output logic [N-1:0]      smode_o,
    output logic [N-1:0]      spol_o,
    output logic [N-1:0]      force_o,
    output logic              omode_o,
    output logic              opol_o,
    output logic [N-1:0]      clr_mask_o,
    output logic [N-1:0]      type_chg_o
);
    logic [N-1:0] enable_q;
    logic [N-1:0] smode_q;
    logic [N-1:0] spol_q;
    logic [N-1:0] force_q;
    logic         omode_q;
    logic         opol_q;
    logic [N-1:0] wline;

    assign wline = wdata_i[N-1:0];

    // Purpose: hold the software-visible configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            smode_q  <= '0;
            spol_q   <= '0;
            force_q  <= '0;
            omode_q  <= 1'b0;
            opol_q   <= 1'b0;
        end else if (wr_i) begin
            case (addr_i)
                OFS_ENABLE: enable_q <= wline;
                OFS_SMODE:  smode_q  <= wline;
                OFS_SPOL:   spol_q   <= wline;
                OFS_FORCE:  force_q  <= wline;
                OFS_OMODE:  omode_q  <= wdata_i[0];
                OFS_OPOL:   opol_q   <= wdata_i[0];
                default: ;
            endcase
        end
    end

    // Purpose: derive the status clear mask and the trigger-type change mask.
    always_comb begin
        clr_mask_o = '0;
        type_chg_o = '0;
        if (wr_i) begin
            if (addr_i == OFS_STATUS) clr_mask_o = wline;
            if (addr_i == OFS_SMODE)  type_chg_o = wline ^ smode_q;
            if (addr_i == OFS_SPOL)   type_chg_o = wline ^ spol_q;
        end
    end

    // Purpose: select read data by offset; unmapped offsets read zero.
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            OFS_ENABLE: rdata_o[N-1:0] = enable_q;
            OFS_STATUS: rdata_o[N-1:0] = status_i;
            OFS_SMODE:  rdata_o[N-1:0] = smode_q;
            OFS_SPOL:   rdata_o[N-1:0] = spol_q;
            OFS_OMODE:  rdata_o[0]     = omode_q;
            OFS_OPOL:   rdata_o[0]     = opol_q;
            OFS_FORCE:  rdata_o[N-1:0] = force_q;
            default:    rdata_o        = '0;
        endcase
    end

    assign enable_o = enable_q;
    assign smode_o  = smode_q;
    assign spol_o   = spol_q;
    assign force_o  = force_q;
    assign omode_o  = omode_q;
    assign opol_o   = opol_q;
endmodule

// File: rtl/irqc_trigger.sv
// Module: per-line trigger qualification and the status register.
// Edge lines latch events until cleared by writing 1; level lines track the
// qualified level. A type change drops the status; force sets it.
// Assumes sync/prev come from irqc_sync and masks from irqc_cfg_regs.
module irqc_trigger #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_i,
    input  logic [N-1:0] prev_i,
    input  logic [N-1:0] smode_i,
    input  logic [N-1:0] spol_i,
    input  logic [N-1:0] force_i,
    input  logic [N-1:0] clr_mask_i,
    input  logic [N-1:0] type_chg_i,
    output logic [N-1:0] edge_evt_o,
    output logic [N-1:0] status_o
);
    logic [N-1:0] status_q;
    logic [N-1:0] status_d;

    for (genvar i = 0; i < N; i++) begin : g_line
        logic rise;
        logic fall;
        logic lvl;
        logic evt;
        logic edge_next;
        logic base_next;

        // Purpose: qualify the synchronised line and form this line's next status.
        always_comb begin
            rise      = sync_i[i] & ~prev_i[i];
            fall      = ~sync_i[i] & prev_i[i];
            lvl       = spol_i[i] ? sync_i[i] : ~sync_i[i];
            evt       = smode_i[i] & (spol_i[i] ? rise : fall);
            edge_next = (status_q[i] & ~clr_mask_i[i]) | evt;
            base_next = smode_i[i] ? edge_next : lvl;
            status_d[i] = (base_next & ~type_chg_i[i]) | force_i[i];
        end

        assign edge_evt_o[i] = evt;
    end

    // Purpose: register the status of every line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else begin
            status_q <= status_d;
        end
    end

    assign status_o = status_q;
endmodule

// File: rtl/irqc_out_stage.sv
// Module: aggregates enabled status into one pending signal and shapes the
// combined output as a level of either sense or a single-cycle pulse.
// Assumes status and enable are registered upstream.
module irqc_out_stage #(
    parameter int unsigned N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] status_i,
    input  logic [N-1:0] enable_i,
    input  logic         omode_i,
    input  logic         opol_i,
    output logic         pending_o,
    output logic         pulse_o,
    output logic         irq_o
);
    logic pending;
    logic pending_q;
    logic pulse_q;
    logic active;

    assign pending = |(status_i & enable_i);

    // Purpose: remember the last pending value and mark its rising moment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_q <= 1'b0;
            pulse_q   <= 1'b0;
        end else begin
            pending_q <= pending;
            pulse_q   <= pending & ~pending_q;
        end
    end

    // Purpose: choose level or pulse shaping and apply the output sense.
    always_comb begin
        active = omode_i ? pulse_q : pending;
        irq_o  = opol_i ? active : ~active;
    end

    assign pending_o = pending;
    assign pulse_o   = pulse_q;
endmodule

// File: rtl/irq_trigger_ctrl.sv
// Module: top of the trigger-configurable interrupt controller.
// Wires synchroniser, configuration registers, trigger logic and output stage.
// Assumes NSRC <= 32 and a single clock domain for the register port.
module irq_trigger_ctrl
    import irqc_pkg::*;
#(
    parameter int unsigned NSRC = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   src_i,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out
);
    logic [NSRC-1:0] sync_w;
    logic [NSRC-1:0] prev_w;
    logic [NSRC-1:0] enable_w;
    logic [NSRC-1:0] smode_w;
    logic [NSRC-1:0] spol_w;
    logic [NSRC-1:0] force_w;
    logic [NSRC-1:0] clr_mask_w;
    logic [NSRC-1:0] type_chg_w;
    logic [NSRC-1:0] edge_evt_w;
    logic [NSRC-1:0] status_w;
    logic            omode_w;
    logic            opol_w;
    logic            pending_w;
    logic            pulse_w;

    irqc_sync #(.W(NSRC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (src_i),
        .sync_o  (sync_w),
        .prev_o  (prev_w)
    );

    irqc_cfg_regs #(.N(NSRC)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (reg_wr),
        .addr_i     (reg_addr),
        .wdata_i    (reg_wdata),
        .status_i   (status_w),
        .rdata_o    (reg_rdata),
        .enable_o   (enable_w),
        .smode_o    (smode_w),
        .spol_o     (spol_w),
        .force_o    (force_w),
        .omode_o    (omode_w),
        .opol_o     (opol_w),
        .clr_mask_o (clr_mask_w),
        .type_chg_o (type_chg_w)
    );

    irqc_trigger #(.N(NSRC)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .sync_i     (sync_w),
        .prev_i     (prev_w),
        .smode_i    (smode_w),
        .spol_i     (spol_w),
        .force_i    (force_w),
        .clr_mask_i (clr_mask_w),
        .type_chg_i (type_chg_w),
        .edge_evt_o (edge_evt_w),
        .status_o   (status_w)
    );

    irqc_out_stage #(.N(NSRC)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .status_i  (status_w),
        .enable_i  (enable_w),
        .omode_i   (omode_w),
        .opol_i    (opol_w),
        .pending_o (pending_w),
        .pulse_o   (pulse_w),
        .irq_o     (irq_out)
    );
endmodule

// File: rtl/irqc_checker.sv
// Module: protocol checker for irq_trigger_ctrl, attached with bind below.
module irqc_checker
    import irqc_pkg::*;
#(
    parameter int unsigned N = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [N-1:0]      status,
    input logic [N-1:0]      smode,
    input logic [N-1:0]      force_q,
    input logic [N-1:0]      enable,
    input logic [N-1:0]      edge_evt,
    input logic              omode,
    input logic              opol,
    input logic              pulse,
    input logic              irq_out
);
    logic clear_all;
    logic [N-1:0] chg_mask;

    assign clear_all = reg_wr && (reg_addr == OFS_STATUS) && (&reg_wdata[N-1:0]);
    assign chg_mask  = (reg_wr && (reg_addr == OFS_SMODE)) ? (reg_wdata[N-1:0] ^ smode) : '0;

    // R4: an all-ones clear leaves only edges caught in the clearing cycle.
    assert_clear_all_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_all && force_q == '0 && !$isunknown(edge_evt))
        |=> ((status & smode) == ($past(edge_evt) & smode)));

    // R6: a mode change drops the status of every changed line.
    assert_type_chg_clr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (force_q == '0 && chg_mask != '0)
        |=> ((status & $past(chg_mask)) == '0));

    // R7: a set force bit sets the status bit on the next edge.
    assert_force_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (force_q != '0) |=> ((status & $past(force_q)) == $past(force_q)));

    // R8: active-high level output equals the enabled pending OR.
    assert_level_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!omode && opol) |-> (irq_out == (|(status & enable))));

    // R9: the pulse never lasts more than one clock.
    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse);
endmodule

bind irq_trigger_ctrl irqc_checker #(.N(NSRC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .status    (status_w),
    .smode     (smode_w),
    .force_q   (force_w),
    .enable    (enable_w),
    .edge_evt  (edge_evt_w),
    .omode     (omode_w),
    .opol      (opol_w),
    .pulse     (pulse_w),
    .irq_out   (irq_out)
);

// File: tb/irq_trigger_ctrl_bench.sv
// Bench: directed corner cases, then seeded random traffic against a
// cycle model kept in bench tasks.
module irq_trigger_ctrl_bench;
    localparam logic [4:0] A_EN = 5'h00, A_ST = 5'h04, A_MD = 5'h08, A_PL = 5'h0C,
                           A_OM = 5'h10, A_OP = 5'h14, A_FC = 5'h18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // model state
    logic [31:0] m_s0 = '0, m_s1 = '0, m_prev = '0, m_stat = '0;
    logic [31:0] m_en = '0, m_md = '0, m_pl = '0, m_fc = '0;
    logic        m_om = 1'b0, m_op = 1'b0, m_pq = 1'b0, m_pulse = 1'b0;

    always #10 clk = ~clk;

    irq_trigger_ctrl u_irq_trigger_ctrl (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic exp_irq();
        logic pend;
        logic act;
        pend = |(m_stat & m_en);
        act  = m_om ? m_pulse : pend;
        return m_op ? act : ~act;
    endfunction

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        case (a)
            A_EN: return m_en;
            A_ST: return m_stat;
            A_MD: return m_md;
            A_PL: return m_pl;
            A_OM: return {31'd0, m_om};
            A_OP: return {31'd0, m_op};
            A_FC: return m_fc;
            default: return 32'd0;
        endcase
    endfunction

    // one clock: update the model from the values driven before the edge
    task automatic tick();
        logic [31:0] rise, fall, ev, lvl, clr, chg, nxt;
        logic pend;
        @(posedge clk);
        rise = m_s1 & ~m_prev;
        fall = ~m_s1 & m_prev;
        ev   = m_md & ((m_pl & rise) | (~m_pl & fall));
        lvl  = (m_pl & m_s1) | (~m_pl & ~m_s1);
        clr  = (reg_wr && reg_addr == A_ST) ? reg_wdata : 32'd0;
        chg  = (reg_wr && reg_addr == A_MD) ? (reg_wdata ^ m_md) :
               (reg_wr && reg_addr == A_PL) ? (reg_wdata ^ m_pl) : 32'd0;
        nxt  = (m_md & ((m_stat & ~clr) | ev)) | (~m_md & lvl);
        nxt  = (nxt & ~chg) | m_fc;
        pend = |(m_stat & m_en);
        m_pulse = pend & ~m_pq;
        m_pq    = pend;
        m_stat  = nxt;
        m_prev  = m_s1;
        m_s1    = m_s0;
        m_s0    = src_i;
        if (reg_wr) begin
            case (reg_addr)
                A_EN: m_en = reg_wdata;
                A_MD: m_md = reg_wdata;
                A_PL: m_pl = reg_wdata;
                A_FC: m_fc = reg_wdata;
                A_OM: m_om = reg_wdata[0];
                A_OP: m_op = reg_wdata[0];
                default: ;
            endcase
        end
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int k = 0; k < 7; k++) begin
            rd(5'(k * 4), v);
            chk("R1 register zero in reset", v, 32'd0);
        end
        chk("R1 irq_out in reset", {31'd0, irq_out}, 32'd1);
        rst_n = 1'b1;

        // R2: read back and unmapped offset
        wr_reg(A_EN, 32'hA5A5_0000);
        rd(A_EN, v); chk("R2 enable readback", v, 32'hA5A5_0000);
        rd(5'h1C, v); chk("R2 unmapped reads zero", v, 32'd0);
        wr_reg(A_EN, 32'd0);

        // R3: rising edge on line 0, status on third edge
        wr_reg(A_MD, 32'h1);
        wr_reg(A_PL, 32'h3);
        wr_reg(A_ST, 32'hFFFF_FFFF);
        src_i[0] = 1'b1;
        tick(); tick();
        rd(A_ST, v); chk("R3 no status after two edges", v & 32'h1, 32'h0);
        tick();
        rd(A_ST, v); chk("R3 rising edge latched", v & 32'h1, 32'h1);

        // R4: write 0 keeps, write 1 clears
        wr_reg(A_ST, 32'h0);
        rd(A_ST, v); chk("R4 write zero keeps", v & 32'h1, 32'h1);
        wr_reg(A_ST, 32'h1);
        rd(A_ST, v); chk("R4 write one clears", v & 32'h1, 32'h0);
        // R4: edge in the same cycle as the clear survives
        src_i[0] = 1'b0;
        tick(); tick(); tick();
        src_i[0] = 1'b1;
        tick(); tick();
        wr_reg(A_ST, 32'h1);
        rd(A_ST, v); chk("R4 coincident edge kept", v & 32'h1, 32'h1);

        // R5: line 1 active-high level
        tick(); tick(); tick();
        rd(A_ST, v); chk("R5 level low not set", v & 32'h2, 32'h0);
        src_i[1] = 1'b1;
        tick(); tick();
        rd(A_ST, v); chk("R5 level latency", v & 32'h2, 32'h0);
        tick();
        rd(A_ST, v); chk("R5 level high set", v & 32'h2, 32'h2);
        wr_reg(A_ST, 32'h2);
        rd(A_ST, v); chk("R5 status write ignored on level", v & 32'h2, 32'h2);

        // R6: polarity change on line 0 drops its latched edge
        wr_reg(A_PL, 32'h2);
        rd(A_ST, v); chk("R6 type change clears", v & 32'h1, 32'h0);

        // R7: force sets, edge stays latched after force released
        wr_reg(A_FC, 32'h1);
        tick();
        rd(A_ST, v); chk("R7 force sets status", v & 32'h1, 32'h1);
        wr_reg(A_FC, 32'h0);
        tick(); tick();
        rd(A_ST, v); chk("R7 edge held after force", v & 32'h1, 32'h1);
        wr_reg(A_ST, 32'h1);

        // R8: level output shaping
        wr_reg(A_EN, 32'h2);
        chk("R8 active-low asserted", {31'd0, irq_out}, 32'd0);
        wr_reg(A_OP, 32'h1);
        chk("R8 active-high asserted", {31'd0, irq_out}, 32'd1);
        wr_reg(A_EN, 32'h0);
        chk("R8 masked line idle", {31'd0, irq_out}, 32'd0);

        // R9: pulse output
        wr_reg(A_OM, 32'h1);
        wr_reg(A_EN, 32'h2);
        chk("R9 no pulse same cycle", {31'd0, irq_out}, 32'd0);
        tick();
        chk("R9 pulse high", {31'd0, irq_out}, 32'd1);
        tick();
        chk("R9 pulse one cycle", {31'd0, irq_out}, 32'd0);

        // random traffic against the model (R2 R3 R4 R5 R6 R7 R8 R9)
        for (int c = 0; c < 4000; c++) begin
            if (($urandom % 4) == 0) src_i = $urandom;
            reg_addr = 5'(($urandom % 8) * 4);
            reg_wr = (($urandom % 6) == 0);
            reg_wdata = $urandom;
            if (reg_addr == A_FC) reg_wdata = reg_wdata & $urandom & $urandom;
            #1;
            chk("R2 random read", reg_rdata, exp_read(reg_addr));
            chk("R8 R9 random irq_out", {31'd0, irq_out}, {31'd0, exp_irq()});
            tick();
            reg_wr = 1'b0;
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule